// File: doc/BRIEF.md
# Single-Wire Bus Master Reset and Slot Sequencer

This block is the controller end of an open-drain single-wire bus. A command picks one of four bus operations: a reset with presence detection, a write-1 slot, a write-0 slot or a read slot. The block drives an active-high pull-down enable for the external open-drain pad. It watches the line through a synchronizer and reports whether any device answered the reset and what bit a read slot returned. All timing is counted in pulses of a one-microsecond tick enable, so the core clock frequency only sets how finely the tick is placed.

Nothing streams through this block, so there is no valid/ready pair. The command side is a one-cycle start strobe qualified by the busy flag, and busy acts as the only back-pressure: a start is taken only while busy is low, and a start seen while busy is high is dropped without effect. When an operation ends, a one-cycle done strobe marks the moment at which the presence flag or the read bit holds its new value.

A reset holds the line low and then releases it. The block then waits for the line to rise. A receive window timed from that rise follows, and the line is sampled for presence inside it. If the line never rises, the operation is cut off at an overall cap, so that a stuck bus cannot stretch the reset indefinitely.

Top module: `ow_master`

## Requirements
- R1: After reset, busy, done, line_pull, presence and rd_bit are all 0.
- R2: A start while busy is low is accepted, and busy is 1 in the next cycle. The op codes are 00 reset, 01 write-1, 10 write-0 and 11 read. A start while busy is high changes neither the running operation's timing nor its result.
- R3: A reset drives line_pull high for exactly 500 ticks and then releases it.
- R4: After a reset release, the receive window starts when the synchronized line is first seen high. Presence is sampled 70 ticks into that window, where a low line means presence is 1. The operation ends 480 ticks after the window opens.
- R5: If the line has not risen by 960 ticks after a reset starts, the operation ends at that point with presence 0.
- R6: A write-0 slot drives line_pull for 60 ticks and lasts 70 ticks in total.
- R7: A write-1 slot drives line_pull for 6 ticks and lasts 70 ticks in total.
- R8: A read slot drives line_pull for 6 ticks and samples the line 15 ticks after the slot starts. The line level sampled (high gives 1) becomes rd_bit, and the slot lasts 70 ticks.
- R9: done is high for exactly one cycle per operation, and it coincides with busy going low.
- R10: presence changes only when a reset ends and rd_bit only when a read ends. All other operations leave both unchanged.
- R11: line_pull is never high while idle. All timing advances only on cycles where us_tick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle enable, once per microsecond |
| start | input | 1 | Command strobe, taken only when idle |
| op | input | 2 | Operation code for start |
| busy | output | 1 | An operation is running |
| done | output | 1 | One-cycle end-of-operation strobe |
| presence | output | 1 | A device answered the last completed reset |
| rd_bit | output | 1 | Bit returned by the last completed read |
| line_pull | output | 1 | Pull-down enable for the open-drain pad |
| line_in | input | 1 | Level seen on the bus line |

## Verification
The checker watches every cycle for the following:
- done is a single cycle and falls together with busy.
- A start taken while idle raises busy.
- The pull-down stays off while idle and never runs longer than the reset low time.
- The pull-down releases only on tick cycles.
- presence and rd_bit move only on a done cycle.

The exact tick counts of each slot and of the reset phases cannot be shown by these properties. The same holds for presence decisions against devices that answer early, answer late or stay silent, for the cap on a stuck-low line, for read values from a device holding the line for long or short times, and for commands dropped mid-operation. Only the bench's scenarios, run against a bus device model, can show those.

// File: rtl/ow_pkg.sv
package ow_pkg;
  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_WR1   = 2'b01,
    OP_WR0   = 2'b10,
    OP_READ  = 2'b11
  } ow_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRIVE,
    ST_RISE,
    ST_LISTEN,
    ST_SLOT
  } ow_state_e;
endpackage

// File: rtl/ow_sync.sv
module ow_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sh[0] <= 1'b1;
          else        sh[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) sh[g] <= 1'b1;
          else        sh[g] <= sh[g-1];
        end
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/ow_us_cnt.sv
module ow_us_cnt #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ow_seq.sv
module ow_seq
  import ow_pkg::*;
#(
  parameter int RST_LOW_US = 500,
  parameter int RST_CAP_US = 960,
  parameter int PRES_AT_US = 70,
  parameter int RX_US      = 480,
  parameter int SLOT_US    = 70,
  parameter int W0_LOW_US  = 60,
  parameter int W1_LOW_US  = 6,
  parameter int RD_LOW_US  = 6,
  parameter int RD_AT_US   = 15,
  parameter int CW         = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic          line_s,
  input  logic [CW-1:0] cnt,
  output logic          cnt_clr,
  output logic          busy,
  output logic          done,
  output logic          presence,
  output logic          rd_bit,
  output logic          line_pull
);
  localparam logic [CW-1:0] L_RST  = CW'(RST_LOW_US - 1);
  localparam logic [CW-1:0] L_CAP  = CW'(RST_CAP_US - 1);
  localparam logic [CW-1:0] L_PRES = CW'(PRES_AT_US - 1);
  localparam logic [CW-1:0] L_RX   = CW'(RX_US - 1);
  localparam logic [CW-1:0] L_SLOT = CW'(SLOT_US - 1);
  localparam logic [CW-1:0] L_W0   = CW'(W0_LOW_US - 1);
  localparam logic [CW-1:0] L_W1   = CW'(W1_LOW_US - 1);
  localparam logic [CW-1:0] L_RDL  = CW'(RD_LOW_US - 1);
  localparam logic [CW-1:0] L_RDS  = CW'(RD_AT_US - 1);

  ow_state_e     state;
  ow_op_e        op_q;
  logic          samp_q;
  logic [CW-1:0] low_end;
  logic          low_hit, cap_hit, pres_hit, rx_hit, slot_hit, rds_hit;

  always_comb begin
    case (op_q)
      OP_RESET: low_end = L_RST;
      OP_WR0:   low_end = L_W0;
      OP_WR1:   low_end = L_W1;
      default:  low_end = L_RDL;
    endcase
  end

  assign low_hit  = tick && (cnt == low_end);
  assign cap_hit  = tick && (cnt == L_CAP);
  assign pres_hit = tick && (cnt == L_PRES);
  assign rx_hit   = tick && (cnt == L_RX);
  assign slot_hit = tick && (cnt == L_SLOT);
  assign rds_hit  = tick && (cnt == L_RDS);

  // counter restarts while idle and when the receive window opens
  assign cnt_clr = (state == ST_IDLE) || (state == ST_RISE && line_s);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      op_q      <= OP_RESET;
      samp_q    <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      presence  <= 1'b0;
      rd_bit    <= 1'b0;
      line_pull <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            op_q      <= ow_op_e'(op);
            state     <= ST_DRIVE;
            busy      <= 1'b1;
            line_pull <= 1'b1;
          end
        end
        ST_DRIVE: begin
          if (low_hit) begin
            line_pull <= 1'b0;
            state     <= (op_q == OP_RESET) ? ST_RISE : ST_SLOT;
          end
        end
        ST_RISE: begin
          if (line_s) begin
            state <= ST_LISTEN;
          end else if (cap_hit) begin
            state    <= ST_IDLE;
            busy     <= 1'b0;
            done     <= 1'b1;
            presence <= 1'b0;
          end
        end
        ST_LISTEN: begin
          if (pres_hit) samp_q <= ~line_s;
          if (rx_hit) begin
            state    <= ST_IDLE;
            busy     <= 1'b0;
            done     <= 1'b1;
            presence <= samp_q;
          end
        end
        ST_SLOT: begin
          if (rds_hit) samp_q <= line_s;
          if (slot_hit) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
            if (op_q == OP_READ) rd_bit <= samp_q;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ow_master.sv
module ow_master #(
  parameter int RST_LOW_US  = 500,
  parameter int RST_CAP_US  = 960,
  parameter int PRES_AT_US  = 70,
  parameter int RX_US       = 480,
  parameter int SLOT_US     = 70,
  parameter int W0_LOW_US   = 60,
  parameter int W1_LOW_US   = 6,
  parameter int RD_LOW_US   = 6,
  parameter int RD_AT_US    = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       start,
  input  logic [1:0] op,
  output logic       busy,
  output logic       done,
  output logic       presence,
  output logic       rd_bit,
  output logic       line_pull,
  input  logic       line_in
);
  // the cap is the longest interval any single phase counts
  localparam int CW = $clog2(RST_CAP_US + 1);

  logic          line_s;
  logic          cnt_clr;
  logic [CW-1:0] cnt;

  ow_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s)
  );

  ow_us_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tick(us_tick), .cnt(cnt)
  );

  ow_seq #(
    .RST_LOW_US(RST_LOW_US), .RST_CAP_US(RST_CAP_US), .PRES_AT_US(PRES_AT_US),
    .RX_US(RX_US), .SLOT_US(SLOT_US), .W0_LOW_US(W0_LOW_US),
    .W1_LOW_US(W1_LOW_US), .RD_LOW_US(RD_LOW_US), .RD_AT_US(RD_AT_US),
    .CW(CW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(us_tick), .start(start), .op(op),
    .line_s(line_s), .cnt(cnt), .cnt_clr(cnt_clr), .busy(busy), .done(done),
    .presence(presence), .rd_bit(rd_bit), .line_pull(line_pull)
  );
endmodule

// File: rtl/ow_master_chk.sv
module ow_master_chk #(
  parameter int RST_LOW_US = 500
) (
  input logic       clk,
  input logic       rst_n,
  input logic       us_tick,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       presence,
  input logic       rd_bit,
  input logic       line_pull
);
  localparam int RW = $clog2(RST_LOW_US + 2);
  logic [RW-1:0] pull_run;

  // ticks counted during the current pull-down stretch
  always_ff @(posedge clk) begin
    if (!rst_n || !line_pull) pull_run <= '0;
    else if (us_tick)         pull_run <= pull_run + 1'b1;
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_idle_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_pull);
  assert_release_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_pull) |-> $past(us_tick));
  assert_low_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pull_run <= RW'(RST_LOW_US));
  assert_presence_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(presence) |-> done);
  assert_rdbit_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_bit) |-> done);
endmodule

bind ow_master ow_master_chk #(.RST_LOW_US(RST_LOW_US)) u_chk (
  .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .start(start), .busy(busy),
  .done(done), .presence(presence), .rd_bit(rd_bit), .line_pull(line_pull)
);

// File: tb/tb_ow_master.sv
`timescale 1ns/1ps
module tb_ow_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       us_tick = 1'b0;
  logic       start = 1'b0;
  logic [1:0] op = 2'b00;
  logic       busy, done, presence, rd_bit, line_pull;
  logic       line_in;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bus device model
  logic [1:0] cur_op = 2'b00;
  bit   dev_present = 0;
  bit   dev_rd0 = 0;
  bit   stuck = 0;
  int   dev_d = 20, dev_w = 100, dev_hold = 30;
  bit   dev_act = 0;
  int   dev_lo = 0, dev_hi = 0, dc = 0;
  logic pull_prev = 1'b0;
  logic dev_low;

  assign dev_low = dev_act && (dc >= dev_lo) && (dc < dev_hi);
  assign line_in = !(line_pull || dev_low || stuck);

  always #5 clk = ~clk;

  ow_master dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .start(start), .op(op),
    .busy(busy), .done(done), .presence(presence), .rd_bit(rd_bit),
    .line_pull(line_pull), .line_in(line_in)
  );

  always @(posedge clk) us_tick <= ($urandom_range(0, 2) == 0);

  always @(posedge clk) begin
    pull_prev <= line_pull;
    if (!rst_n) begin
      dev_act <= 0;
    end else if (cur_op == 2'b00 && pull_prev && !line_pull && dev_present) begin
      dev_act <= 1; dc <= 0; dev_lo <= dev_d; dev_hi <= dev_d + dev_w;
    end else if (cur_op == 2'b11 && !pull_prev && line_pull && dev_rd0) begin
      dev_act <= 1; dc <= 0; dev_lo <= 0; dev_hi <= dev_hold;
    end else if (dev_act && us_tick) begin
      dc <= dc + 1;
      if (dc >= 400) dev_act <= 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  function automatic int exp_low(input logic [1:0] o);
    case (o)
      2'b00: return 500;
      2'b10: return 60;
      default: return 6;
    endcase
  endfunction

  function automatic bit exp_pres(input bit present, input bit stk, input int d, input int w);
    return !stk && present && d <= 65 && (d + w) >= 75;
  endfunction

  function automatic bit exp_read(input bit drv0, input int hold);
    return !(drv0 && hold > 16);
  endfunction

  bit exp_p = 0, exp_r = 0;

  task automatic run_op(input logic [1:0] opc, input int inject);
    int pt = 0, bt = 0, dn = 0;
    bit acc, idle_at_done = 0;
    string tag;
    cur_op = opc;
    @(negedge clk); op = opc; start = 1'b1;
    @(negedge clk); start = 1'b0; acc = busy;
    for (int i = 0; i < 8000; i++) begin
      if (line_pull && us_tick) pt++;
      if (busy && us_tick) bt++;
      if (done) begin dn++; idle_at_done = !busy; break; end
      if (i == inject) begin start = 1'b1; op = ~opc; end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    @(negedge clk);
    if (done) dn++;
    chk("R2 accept", acc, 1);
    chk("R9 single done", dn, 1);
    chk("R9 idle at done", idle_at_done, 1);
    if (opc == 2'b00) begin
      chk("R3 reset low ticks", pt, 500);
      if (stuck) chk("R5 cap ticks", bt, 960);
      else chk_rng("R4 reset length", bt, 980, 986);
      exp_p = exp_pres(dev_present, stuck, dev_d, dev_w);
      chk("R4 presence", presence, exp_p);
      chk("R10 rd_bit kept", rd_bit, exp_r);
    end else begin
      tag = (opc == 2'b10) ? "R6" : (opc == 2'b01) ? "R7" : "R8";
      chk({tag, " low ticks"}, pt, exp_low(opc));
      chk({tag, " slot ticks"}, bt, 70);
      if (opc == 2'b11) begin
        exp_r = exp_read(dev_rd0, dev_hold);
        chk("R8 read bit", rd_bit, exp_r);
      end else begin
        chk("R10 rd_bit kept", rd_bit, exp_r);
      end
      chk("R10 presence kept", presence, exp_p);
    end
  endtask

  task automatic summary;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 line_pull", line_pull, 0);
    chk("R1 presence", presence, 0);
    chk("R1 rd_bit", rd_bit, 0);
    // directed: present device, then late device, then stuck line
    dev_present = 1; dev_d = 30; dev_w = 120;
    run_op(2'b00, -1);
    dev_d = 80; dev_w = 100;
    run_op(2'b00, -1);
    dev_present = 1; dev_d = 15; dev_w = 60;
    run_op(2'b00, -1);
    stuck = 1;
    run_op(2'b00, -1);
    stuck = 0;
    // directed reads: long hold, short hold, none
    dev_rd0 = 1; dev_hold = 30; run_op(2'b11, -1);
    dev_hold = 8; run_op(2'b11, -1);
    dev_rd0 = 0; run_op(2'b11, -1);
    // ignored starts mid-operation (R2)
    dev_rd0 = 1; dev_hold = 30; run_op(2'b11, 10);
    run_op(2'b10, 5);
    run_op(2'b01, 3);
    // random mix
    for (int k = 0; k < 40; k++) begin
      logic [1:0] o;
      o = 2'($urandom_range(0, 3));
      dev_present = ($urandom_range(0, 3) != 0);
      dev_d = $urandom_range(15, 60);
      dev_w = $urandom_range(60, 240);
      dev_rd0 = $urandom_range(0, 1);
      dev_hold = ($urandom_range(0, 1) != 0) ? 30 : 8;
      run_op(o, ($urandom_range(0, 3) == 0) ? 4 : -1);
    end
    summary();
  end
endmodule